// File: doc/BRIEF.md
# I2C Register-Access Target Port

This block is an I2C target that lets a bus host read and write a bank of sixteen 8-bit control registers. It samples SCL and SDA through two-flop synchronisers on the system clock and pulls SDA low through an open-drain enable output. It recognises start, repeated start and stop conditions. It answers a 7-bit address whose upper six bits are fixed and whose lowest bit comes from a strap input.

A write transaction carries a pointer byte followed by data bytes. The pointer byte holds a register index and a flag that makes the index advance after each data byte. A read transaction shifts out the register the pointer selects, starting right after the address byte. When the flag is set it advances the same way, so a host can move a block of registers in one transaction. The whole bank is also visible in parallel on a flat output bus, register k on bits [8k+7:8k].

Top module: `i2c_reg_port`

## Requirements
- R1: After reset the SDA pull-down enable is 0, all sixteen registers read 0x00, and the pointer index and auto-increment flag are 0.
- R2: The target acknowledges (drives SDA low during the ninth clock) an address byte whose bits [7:1] equal binary 001000 followed by the strap level. Bit 0 of the address byte selects a read when 1 and a write when 0.
- R3: On an address mismatch the target gives no acknowledge and never drives SDA until the next start condition. Register contents are unchanged.
- R4: In a write, the first byte after the address loads the pointer. Each further byte is written to the register the pointer selects, and every received byte is acknowledged.
- R5: With pointer bit 7 at 0, the index stays constant, so successive data bytes (written or read) all use the same register.
- R6: With pointer bit 7 at 1, the index advances by one after each data byte written, wrapping from 15 to 0.
- R7: In a read, the target shifts out, MSB first, the register selected by the current pointer. With pointer bit 7 at 1 it advances after each byte, wrapping from 15 to 0. A read with no preceding pointer write uses the pointer left by the last one.
- R8: When the host answers a read byte with not-acknowledge, the target releases SDA and drives nothing more until a stop or repeated start.
- R9: Pointer bits 6 to 4 are reserved and ignored: only bit 7 and bits 3 to 0 affect behaviour.
- R10: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level (wired bus value) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_lsb_i | input | 1 | Strap setting bit 0 of the target address |
| reg_bank_o | output | 128 | All registers in parallel, register k on bits [8k+7:8k] |

## Verification
The assertions assume that SCL stays low for longer than the synchroniser delay of three system clocks. They also assume that the host only makes start and stop conditions while the target has SDA released, and that the strap does not change inside a transaction. The stimulus holds every SCL phase for eight system clocks. It changes SDA only a quarter bit after SCL falls, issues repeated starts and stops only after an acknowledge or a not-acknowledge has been released, and changes the strap only between transactions.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_WDATA,
    ST_W_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } port_state_e;
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '1;
        else         stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '1;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // SDA edges while SCL is held high
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file #(
  parameter  int unsigned NREG  = 16,
  parameter  int unsigned DW    = 8,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   widx_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [IDX_W-1:0]   ridx_i,
  output logic [DW-1:0]      rdata_o,
  output logic [NREG*DW-1:0] bank_o
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_q[g] <= '0;
      else if (we_i && (widx_i == IDX_W'(g)))        regs_q[g] <= wdata_i;
    end
    assign bank_o[g*DW +: DW] = regs_q[g];
  end

  assign rdata_o = regs_q[ridx_i];
endmodule

// File: rtl/i2c_reg_port.sv
module i2c_reg_port
  import i2c_reg_pkg::*;
#(
  parameter  int unsigned NREG        = 16,
  parameter  logic [5:0]  ADDR_HI     = 6'b001000,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned DW          = BYTE_W,
  localparam int unsigned IDX_W       = $clog2(NREG),
  localparam int unsigned CNT_W       = $clog2(DW + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic               addr_lsb_i,
  output logic [NREG*DW-1:0] reg_bank_o
);
  logic             scl_s, sda_s;
  logic             scl_rise, scl_fall, bus_start, bus_stop;
  port_state_e      state_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic [DW-1:0]    shreg_q, tx_q, rd_data;
  logic             rw_q, mack_q, sda_oe_q;
  logic [IDX_W-1:0] ptr_idx_q;
  logic             ptr_inc_q;
  logic             byte_done, wr_en;

  i2c_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    ({scl_s, sda_s})
  );

  i2c_bus_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  i2c_reg_file #(.NREG(NREG), .DW(DW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .widx_i  (ptr_idx_q),
    .wdata_i (shreg_q),
    .ridx_i  (ptr_idx_q),
    .rdata_o (rd_data),
    .bank_o  (reg_bank_o)
  );

  assign byte_done = (bit_cnt_q == CNT_W'(DW));
  assign wr_en     = (state_q == ST_WDATA) && scl_fall && byte_done && !bus_start && !bus_stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      tx_q      <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      sda_oe_q  <= 1'b0;
      ptr_idx_q <= '0;
      ptr_inc_q <= 1'b0;
    end else if (bus_stop) begin
      state_q  <= ST_IDLE;
      sda_oe_q <= 1'b0;
    end else if (bus_start) begin
      state_q   <= ST_ADDR;
      bit_cnt_q <= '0;
      sda_oe_q  <= 1'b0;
    end else begin
      if (scl_rise) begin
        unique case (state_q)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            shreg_q   <= {shreg_q[DW-2:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
          ST_RDATA: bit_cnt_q <= bit_cnt_q + 1'b1;
          ST_RACK:  mack_q    <= ~sda_s;
          default: ;
        endcase
      end
      if (scl_fall) begin
        unique case (state_q)
          ST_ADDR: if (byte_done) begin
            if (shreg_q[DW-1:1] == {ADDR_HI, addr_lsb_i}) begin
              sda_oe_q <= 1'b1;
              rw_q     <= shreg_q[0];
              state_q  <= ST_ADDR_ACK;
            end else begin
              state_q  <= ST_IGNORE;
            end
          end
          ST_ADDR_ACK: begin
            bit_cnt_q <= '0;
            if (rw_q) begin
              tx_q     <= rd_data;
              sda_oe_q <= ~rd_data[DW-1];
              state_q  <= ST_RDATA;
            end else begin
              sda_oe_q <= 1'b0;
              state_q  <= ST_PTR;
            end
          end
          ST_PTR: if (byte_done) begin
            ptr_inc_q <= shreg_q[DW-1];
            ptr_idx_q <= shreg_q[IDX_W-1:0];
            sda_oe_q  <= 1'b1;
            state_q   <= ST_W_ACK;
          end
          ST_WDATA: if (byte_done) begin
            if (ptr_inc_q) ptr_idx_q <= ptr_idx_q + 1'b1;
            sda_oe_q <= 1'b1;
            state_q  <= ST_W_ACK;
          end
          ST_W_ACK: begin
            sda_oe_q  <= 1'b0;
            bit_cnt_q <= '0;
            state_q   <= ST_WDATA;
          end
          ST_RDATA: begin
            if (byte_done) begin
              sda_oe_q <= 1'b0;
              if (ptr_inc_q) ptr_idx_q <= ptr_idx_q + 1'b1;
              state_q  <= ST_RACK;
            end else begin
              tx_q     <= {tx_q[DW-2:0], 1'b0};
              sda_oe_q <= ~tx_q[DW-2];
            end
          end
          ST_RACK: begin
            if (mack_q) begin
              tx_q      <= rd_data;
              sda_oe_q  <= ~rd_data[DW-1];
              bit_cnt_q <= '0;
              state_q   <= ST_RDATA;
            end else begin
              state_q   <= ST_IGNORE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = sda_oe_q;
endmodule

// File: rtl/i2c_reg_port_chk.sv
module i2c_reg_port_chk
  import i2c_reg_pkg::*;
#(
  parameter  int unsigned NREG  = 16,
  parameter  int unsigned DW    = 8,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               scl_i,
  input logic               sda_oe_o,
  input port_state_e        state_i,
  input logic [IDX_W-1:0]   ptr_idx_i,
  input logic               ptr_inc_i,
  input logic               wr_en_i,
  input logic [DW-1:0]      wr_data_i,
  input logic [NREG*DW-1:0] bank_i
);
  logic             wr_en_q, inc_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_q <= 1'b0;
      inc_q   <= 1'b0;
      idx_q   <= '0;
      data_q  <= '0;
    end else begin
      wr_en_q <= wr_en_i;
      inc_q   <= ptr_inc_i;
      idx_q   <= ptr_idx_i;
      data_q  <= wr_data_i;
    end
  end

  assert_sda_only_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  assert_silent_when_ignoring_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IGNORE) |-> !sda_oe_o);

  assert_release_after_nack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_i) == ST_RACK && state_i == ST_IGNORE) |-> !sda_oe_o);

  assert_write_lands_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |-> (bank_i[int'(idx_q)*DW +: DW] == data_q));

  assert_index_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_q && !inc_q) |-> (ptr_idx_i == idx_q));

  assert_index_advances_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_q && inc_q) |-> (ptr_idx_i == idx_q + 1'b1));
endmodule

bind i2c_reg_port i2c_reg_port_chk #(.NREG(NREG), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .sda_oe_o  (sda_oe_o),
  .state_i   (state_q),
  .ptr_idx_i (ptr_idx_q),
  .ptr_inc_i (ptr_inc_q),
  .wr_en_i   (wr_en),
  .wr_data_i (shreg_q),
  .bank_i    (reg_bank_o)
);

// File: tb/tb_i2c_reg_port.sv
module tb_i2c_reg_port;
  localparam int NREG = 16;
  localparam int Q    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic strap = 1'b0;
  logic dut_oe;
  logic sda_line;
  logic [NREG*8-1:0] bank;

  always #5 clk = ~clk;
  assign sda_line = ~(dut_oe | m_low);

  i2c_reg_port dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .sda_oe_o   (dut_oe),
    .addr_lsb_i (strap),
    .reg_bank_o (bank)
  );

  int checks = 0;
  int fails  = 0;
  int r10_viol = 0;
  bit done = 1'b0;
  logic [7:0] model [NREG];
  logic [3:0] cur_idx = '0;
  logic       cur_inc = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] got_byte;
  event       rd_ev;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic clock_bit(input logic drive_low, output logic s);
    m_low = drive_low; wait_q();
    scl = 1'b1;        wait_q();
    s = sda_line;      wait_q();
    scl = 1'b0;        wait_q();
  endtask

  task automatic i2c_start();
    m_low = 1'b0; wait_q();
    scl = 1'b1;   wait_q();
    m_low = 1'b1; wait_q();
    scl = 1'b0;   wait_q();
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; wait_q();
    scl = 1'b1;   wait_q();
    m_low = 1'b0; wait_q();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(~b[i], s);
    clock_bit(1'b0, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic send_ack);
    logic s;
    logic [7:0] b = '0;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b0, s);
      b = {b[6:0], s};
    end
    got_byte = b;
    -> rd_ev;
    clock_bit(send_ack, s);
  endtask

  task automatic check_bank(input string tag);
    for (int k = 0; k < NREG; k++)
      check(bank[k*8 +: 8] === model[k], tag, bank[k*8 +: 8], model[k]);
  endtask

  // full write transaction; the model follows the pointer rules when acknowledged
  task automatic wr_txn(input logic [7:0] addr, input logic [7:0] ptr, input int n,
                        input logic [7:0] d0, input logic [7:0] d1,
                        input logic [7:0] d2, input logic [7:0] d3,
                        input logic exp_ack, input string tag);
    logic ack;
    logic [7:0] d [4];
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    i2c_start();
    wr_byte(addr, ack);
    check(ack == exp_ack, {tag, " addr ack"}, ack, exp_ack);
    wr_byte(ptr, ack);
    check(ack == exp_ack, {tag, " ptr ack"}, ack, exp_ack);
    if (exp_ack) begin
      cur_idx = ptr[3:0];
      cur_inc = ptr[7];
    end
    for (int k = 0; k < n; k++) begin
      wr_byte(d[k], ack);
      check(ack == exp_ack, {tag, " data ack"}, ack, exp_ack);
      if (exp_ack) begin
        model[cur_idx] = d[k];
        if (cur_inc) cur_idx = cur_idx + 1'b1;
      end
    end
    i2c_stop();
  endtask

  // read phase: start must already be issued
  task automatic rd_seq(input logic [7:0] addr, input int n, input string tag);
    logic ack, s;
    wr_byte(addr, ack);
    check(ack == 1'b1, {tag, " read addr ack R2"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(model[cur_idx]);
      tag_q.push_back(tag);
      if (cur_inc) cur_idx = cur_idx + 1'b1;
      rd_byte(k != n - 1);
    end
    // R8: after not-acknowledge the line must stay released
    clock_bit(1'b0, s);
    check(s == 1'b1 && dut_oe == 1'b0, "R8 SDA released after NACK", {s, dut_oe}, 2'b10);
  endtask

  task automatic set_ptr(input logic [7:0] addr_w, input logic [7:0] ptr);
    logic ack;
    i2c_start();
    wr_byte(addr_w, ack);
    check(ack, "R2 ptr-set addr ack", ack, 1);
    wr_byte(ptr, ack);
    check(ack, "R4 ptr ack", ack, 1);
    cur_idx = ptr[3:0];
    cur_inc = ptr[7];
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(rd_ev);
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected read byte", got_byte, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got_byte === e, t, got_byte, e);
      end
    end
  end

  // R10 observer: drive edits only while SCL low
  initial begin
    logic oe_prev;
    oe_prev = 1'b0;
    forever begin
      @(posedge clk);
      #3;
      if (rst_n && dut_oe !== oe_prev && scl) r10_viol++;
      oe_prev = dut_oe;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NREG; k++) model[k] = 8'h00;
    repeat (4) @(negedge clk);
    check(dut_oe == 1'b0, "R1 reset SDA released", dut_oe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(dut_oe == 1'b0, "R1 SDA released after reset", dut_oe, 0);
    check_bank("R1 reset bank zero");

    // R1: read with no pointer write uses index 0
    i2c_start();
    rd_seq(8'h21, 1, "R1 read at reset pointer");
    i2c_stop();

    // R2/R4 simple write with strap 0
    wr_txn(8'h20, 8'h03, 1, 8'hA5, 8'h00, 8'h00, 8'h00, 1'b1, "R4 single write");
    check_bank("R4 bank after write");

    // R5 index held
    wr_txn(8'h20, 8'h07, 2, 8'h11, 8'h22, 8'h00, 8'h00, 1'b1, "R5 fixed index write");
    check_bank("R5 bank after fixed writes");

    // R6 auto-increment with wrap
    wr_txn(8'h20, 8'h8E, 4, 8'h01, 8'h02, 8'h03, 8'h04, 1'b1, "R6 block write wrap");
    check_bank("R6 bank after wrapped block");

    // R9 reserved bits
    wr_txn(8'h20, 8'h75, 2, 8'h5A, 8'h5B, 8'h00, 8'h00, 1'b1, "R9 reserved set, no inc");
    check_bank("R9 bank reserved no inc");
    wr_txn(8'h20, 8'hF2, 2, 8'h66, 8'h77, 8'h00, 8'h00, 1'b1, "R9 reserved set, inc");
    check_bank("R9 bank reserved inc");

    // R3 mismatches
    wr_txn(8'h22, 8'h04, 1, 8'hEE, 8'h00, 8'h00, 8'h00, 1'b0, "R3 wrong strap bit");
    check_bank("R3 bank unchanged (lsb)");
    wr_txn(8'h40, 8'h04, 1, 8'hEE, 8'h00, 8'h00, 8'h00, 1'b0, "R3 wrong upper bits");
    check_bank("R3 bank unchanged (upper)");

    // R2 strap 1
    strap = 1'b1;
    repeat (4) @(negedge clk);
    wr_txn(8'h22, 8'h09, 1, 8'h99, 8'h00, 8'h00, 8'h00, 1'b1, "R2 strap high write");
    wr_txn(8'h20, 8'h0A, 1, 8'hCC, 8'h00, 8'h00, 8'h00, 1'b0, "R3 old address rejected");
    check_bank("R2 bank after strap change");

    // R7 block read with wrap, repeated start
    set_ptr(8'h22, 8'h8E);
    i2c_start();
    rd_seq(8'h23, 4, "R7 block read wrap");
    i2c_stop();

    // R5 read without increment
    set_ptr(8'h22, 8'h03);
    i2c_start();
    rd_seq(8'h23, 2, "R5 read fixed index");
    i2c_stop();

    // R7 read using pointer left from earlier transaction
    i2c_start();
    rd_seq(8'h23, 1, "R7 read with retained pointer");
    i2c_stop();

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
    check(r10_viol == 0, "R10 SDA drive changed with SCL high", r10_viol, 0);
    check(dut_oe == 1'b0, "R8 idle after stop", dut_oe, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule